// File: doc/BRIEF.md
# DMA Channel Transfer-Mode Sequencer

This block is the per-channel control core of a four-channel DMA controller. Each clock cycle it decides whether its channel issues one more transfer. The decision uses the channel's transfer mode, its hardware request line, a software request, the channel mask and the channel's terminal-count state. A controller-wide disable bit in the command register can also stop it. It does not generate addresses, arbitrate between channels or move data. It emits a one-cycle transfer strobe that the surrounding datapath acts on.

The block holds the channel's 16-bit current count. The count steps down once per transfer, and the block detects the wrap past zero as terminal count. The block also drives the channel's two bits of the shared status byte: a terminal-count bit that software clears by reading, and a request bit.

The four modes handle the request flag differently:
- **Demand** tracks the request line after every transfer.
- **Single** drops the flag after each transfer.
- **Block** holds the flag until terminal count.
- **Cascade** only mirrors the request line and never transfers.

Top module: `dma_chan_seq`

## Requirements
- R1: The transfer mode is taken from bits 5:4 of the byte written with `mode_wr`. The codes are 00 demand, 01 single, 10 block and 11 cascade. Mode is demand after reset.
- R2: `xfer_strobe` is high in a cycle exactly when all of the following hold:
  - the request flag or the pending software request is set;
  - the channel is unmasked;
  - terminal count has not been reached;
  - bit 2 of the command register is clear;
  - the mode is not cascade.
- R3: In demand mode the request flag loads the `drq` value at every clock edge, whether or not a transfer happened.
- R4: In single mode a transfer clears the request flag at that edge. On a cycle without a transfer the flag becomes (flag OR `drq`).
- R5: In block mode the request flag is held through transfers until the transfer that reaches terminal count. That transfer, and every edge after it while terminal count is reached, loads `drq`. Before terminal count, a cycle without a transfer gives (flag OR `drq`).
- R6: In cascade mode the request flag loads `drq` at every edge, and `xfer_strobe` stays low.
- R7: Each transfer decrements `cur_count` by one, modulo 2^16. A `count_wr` loads `count_din` instead, takes priority over a transfer in the same cycle, and clears terminal-count state.
- R8: A transfer issued while `cur_count` is 0 wraps the count to 0xFFFF and raises `tc_flag`. The flag stays high until the next `count_wr`.
- R9: `status_byte` bit CH_IDX is the terminal-count bit and bit CH_IDX+4 is the request flag. All other bits are 0. The TC bit is set by a transfer at count 0 and cleared by `status_rd`. When both occur in the same cycle, the set wins. `status_rd` leaves the request bit unchanged.
- R10: `sw_req` sets a pending software request. That request keeps transfers running while the channel can transfer. It is dropped at the first edge where the channel cannot transfer, unless `sw_req` is asserted again in that cycle.
- R11: Synchronous active-high `rst` does the following:
  - clears the status byte, the count, terminal-count state and the software request;
  - clears the command register;
  - sets the mask;
  - selects demand mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Load the mode byte |
| mode_din | input | 8 | Mode byte; bits 5:4 hold the transfer mode |
| cmd_wr | input | 1 | Load the command byte |
| cmd_din | input | 8 | Command byte; bit 2 disables the controller |
| mask_wr | input | 1 | Load the channel mask |
| mask_din | input | 1 | New mask value (1 = masked) |
| count_wr | input | 1 | Load the current count |
| count_din | input | 16 | Count value to load |
| drq | input | 1 | Hardware request line |
| sw_req | input | 1 | Software request pulse |
| status_rd | input | 1 | Status read strobe; clears the TC bit |
| xfer_strobe | output | 1 | A transfer is issued this cycle |
| tc_flag | output | 1 | Terminal count reached since the last count load |
| status_byte | output | 8 | TC bit at CH_IDX, request bit at CH_IDX+4 |
| cur_count | output | 16 | Current count |

## Verification
Two events can land in the same cycle:
- **TC set against status read.** A transfer at count zero sets the TC bit while a status read tries to clear it. The bench provokes this by asserting `status_rd` exactly in the cycle its model predicts a transfer at count zero. It judges that the TC bit is still set afterwards while the request bit is untouched.
- **Count load against transfer.** A count load meets an issued transfer. The loaded value must win and terminal-count state must clear.

Each of these collisions is compared against the behavioural model cycle by cycle, together with the ordinary outputs.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    XM_DEMAND  = 2'b00,
    XM_SINGLE  = 2'b01,
    XM_BLOCK   = 2'b10,
    XM_CASCADE = 2'b11
  } xfer_mode_e;

  // Request-flag successor for one clock edge.
  function automatic logic req_next(
    input xfer_mode_e m,
    input logic       fired,
    input logic       tc_done,
    input logic       tc_hit,
    input logic       req,
    input logic       drq
  );
    logic r;
    case (m)
      XM_SINGLE: r = fired ? 1'b0 : (req | drq);
      XM_BLOCK: begin
        if (fired) r = tc_hit ? drq : req;
        else       r = tc_done ? drq : (req | drq);
      end
      default:   r = drq;
    endcase
    return r;
  endfunction

  // Software request survives only while the channel can run.
  function automatic logic sw_next(
    input logic sw_set,
    input logic sw_now,
    input logic can_run
  );
    return sw_set | (sw_now & can_run);
  endfunction

endpackage

// File: rtl/dma_chan_cfg.sv
module dma_chan_cfg
  import dma_seq_pkg::*;
#(
  parameter int MODE_LSB = 4,
  parameter int DIS_BIT  = 2,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [BYTE_W-1:0] mode_din,
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] cmd_din,
  input  logic              mask_wr,
  input  logic              mask_din,
  output xfer_mode_e        mode,
  output logic              disabled,
  output logic              masked
);

  logic [1:0] mode_q;
  logic       dis_q;
  logic       mask_q;
  logic       unused_cfg_bits;

  assign unused_cfg_bits = ^{mode_din, cmd_din};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 2'b00;
      dis_q  <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      if (mode_wr) mode_q <= mode_din[MODE_LSB +: 2];
      if (cmd_wr)  dis_q  <= cmd_din[DIS_BIT];
      if (mask_wr) mask_q <= mask_din;
    end
  end

  assign mode     = xfer_mode_e'(mode_q);
  assign disabled = dis_q;
  assign masked   = mask_q;

  // R11: reset leaves the channel masked, enabled and in demand mode
  a_r11_reset_cfg: assert property (@(posedge clk)
    rst |=> (masked && !disabled && mode == XM_DEMAND));

  // R1: a mode write lands its field in the next cycle
  a_r1_mode_load: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> mode == xfer_mode_e'($past(mode_din[MODE_LSB +: 2])));

endmodule

// File: rtl/dma_chan_count.sv
module dma_chan_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             fire,
  output logic [CNT_W-1:0] count,
  output logic             tc_done,
  output logic             tc_hit
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ALL1 = '1;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return c - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             tc_q;

  assign tc_hit = fire && (cnt_q == CNT_ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_ZERO;
      tc_q  <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      tc_q  <= 1'b0;
    end else if (fire) begin
      cnt_q <= step_down(cnt_q);
      if (tc_hit) tc_q <= 1'b1;
    end
  end

  assign count   = cnt_q;
  assign tc_done = tc_q;

  // R7: a transfer steps the count down by exactly one
  a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
    (fire && !load) |=> count == $past(count) - 1'b1);

  // R7: without a transfer or load the count holds
  a_r7_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!fire && !load) |=> $stable(count));

  // R7: a load wins and clears terminal state
  a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_val) && !tc_done));

  // R8: the zero transfer wraps to all ones and raises terminal count
  a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
    (tc_hit && !load) |=> (count == CNT_ALL1 && tc_done));

  // R8: terminal count is sticky until a load
  a_r8_tc_sticky: assert property (@(posedge clk) disable iff (rst)
    (tc_done && !load) |=> tc_done);

endmodule

// File: rtl/dma_chan_req.sv
module dma_chan_req
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  xfer_mode_e mode,
  input  logic       fire,
  input  logic       tc_done,
  input  logic       tc_hit,
  input  logic       can_run,
  input  logic       drq,
  input  logic       sw_req,
  output logic       req_flag,
  output logic       pending
);

  logic req_q;
  logic sw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      sw_q  <= 1'b0;
    end else begin
      req_q <= req_next(mode, fire, tc_done, tc_hit, req_q, drq);
      sw_q  <= sw_next(sw_req, sw_q, can_run);
    end
  end

  assign req_flag = req_q;
  assign pending  = req_q | sw_q;

  // R4: single mode drops the flag after each transfer
  a_r4_single_clear: assert property (@(posedge clk) disable iff (rst)
    (fire && mode == XM_SINGLE) |=> !req_flag);

  // R5: block mode keeps a set flag until terminal count
  a_r5_block_hold: assert property (@(posedge clk) disable iff (rst)
    (fire && mode == XM_BLOCK && req_flag && !tc_hit) |=> req_flag);

  // R3: demand mode copies the request line each edge
  a_r3_demand_follow: assert property (@(posedge clk) disable iff (rst)
    (mode == XM_DEMAND) |=> req_flag == $past(drq));

  // R10: a software request is dropped once the channel cannot run
  a_r10_sw_drop: assert property (@(posedge clk) disable iff (rst)
    (!can_run && !sw_req && !req_flag && !drq && mode != XM_BLOCK) |=> !pending);

endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status #(
  parameter int CH_IDX = 2,
  parameter int CH_NUM = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tc_hit,
  input  logic                rd,
  input  logic                req_flag,
  output logic [2*CH_NUM-1:0] status
);

  localparam int STAT_W  = 2 * CH_NUM;
  localparam int REQ_POS = CH_IDX + CH_NUM;

  logic tc_bit;

  always_ff @(posedge clk) begin
    if (rst)         tc_bit <= 1'b0;
    else if (tc_hit) tc_bit <= 1'b1;
    else if (rd)     tc_bit <= 1'b0;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i == CH_IDX) begin : g_tc
      assign status[i] = tc_bit;
    end else if (i == REQ_POS) begin : g_req
      assign status[i] = req_flag;
    end else begin : g_zero
      assign status[i] = 1'b0;
    end
  end

  // R9: a terminal-count event wins over a simultaneous read
  a_r9_hit_wins: assert property (@(posedge clk) disable iff (rst)
    tc_hit |=> status[CH_IDX]);

  // R9: a read alone clears the TC bit
  a_r9_rd_clears: assert property (@(posedge clk) disable iff (rst)
    (rd && !tc_hit) |=> !status[CH_IDX]);

  // R9: only the two channel bits may be set
  a_r9_layout: assert property (@(posedge clk) disable iff (rst)
    $countones(status) <= 2);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int CH_IDX   = 2,
  parameter int CH_NUM   = 4,
  parameter int CNT_W    = 16,
  parameter int MODE_LSB = 4,
  parameter int DIS_BIT  = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_wr,
  input  logic [7:0]   mode_din,
  input  logic         cmd_wr,
  input  logic [7:0]   cmd_din,
  input  logic         mask_wr,
  input  logic         mask_din,
  input  logic         count_wr,
  input  logic [15:0]  count_din,
  input  logic         drq,
  input  logic         sw_req,
  input  logic         status_rd,
  output logic         xfer_strobe,
  output logic         tc_flag,
  output logic [7:0]   status_byte,
  output logic [15:0]  cur_count
);

  localparam int STAT_W = 2 * CH_NUM;

  xfer_mode_e       mode;
  logic             disabled;
  logic             masked;
  logic             tc_done;
  logic             tc_hit;
  logic             req_flag;
  logic             pending;
  logic             can_run;
  logic             fire;
  logic [CNT_W-1:0] count;
  logic [STAT_W-1:0] status;

  dma_chan_cfg #(.MODE_LSB(MODE_LSB), .DIS_BIT(DIS_BIT), .BYTE_W(8)) cfg_i (
    .clk(clk), .rst(rst),
    .mode_wr(mode_wr), .mode_din(mode_din),
    .cmd_wr(cmd_wr), .cmd_din(cmd_din),
    .mask_wr(mask_wr), .mask_din(mask_din),
    .mode(mode), .disabled(disabled), .masked(masked)
  );

  assign can_run = !masked && !tc_done && !disabled && (mode != XM_CASCADE);
  assign fire    = pending && can_run;

  dma_chan_count #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst),
    .load(count_wr), .load_val(count_din[CNT_W-1:0]),
    .fire(fire),
    .count(count), .tc_done(tc_done), .tc_hit(tc_hit)
  );

  dma_chan_req req_i (
    .clk(clk), .rst(rst),
    .mode(mode), .fire(fire), .tc_done(tc_done), .tc_hit(tc_hit),
    .can_run(can_run), .drq(drq), .sw_req(sw_req),
    .req_flag(req_flag), .pending(pending)
  );

  dma_chan_status #(.CH_IDX(CH_IDX), .CH_NUM(CH_NUM)) stat_i (
    .clk(clk), .rst(rst),
    .tc_hit(tc_hit), .rd(status_rd), .req_flag(req_flag),
    .status(status)
  );

  assign xfer_strobe = fire;
  assign tc_flag     = tc_done;
  assign status_byte = status;
  assign cur_count   = count;

  // R6: a cascade channel never issues a transfer
  a_r6_cascade_idle: assert property (@(posedge clk) disable iff (rst)
    (mode == XM_CASCADE) |-> !xfer_strobe);

  // R2: controller disable or mask block every transfer
  a_r2_blocked: assert property (@(posedge clk) disable iff (rst)
    (disabled || masked || tc_flag) |-> !xfer_strobe);

endmodule

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb_top;

  localparam int CH = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wr = 0, cmd_wr = 0, mask_wr = 0, mask_din = 0, count_wr = 0;
  logic [7:0]  mode_din = 0, cmd_din = 0;
  logic [15:0] count_din = 0;
  logic        drq = 0, sw_req = 0, status_rd = 0;
  logic        xfer_strobe, tc_flag;
  logic [7:0]  status_byte;
  logic [15:0] cur_count;

  always #4 clk = ~clk;

  dma_chan_seq dut_i (
    .clk(clk), .rst(rst),
    .mode_wr(mode_wr), .mode_din(mode_din),
    .cmd_wr(cmd_wr), .cmd_din(cmd_din),
    .mask_wr(mask_wr), .mask_din(mask_din),
    .count_wr(count_wr), .count_din(count_din),
    .drq(drq), .sw_req(sw_req), .status_rd(status_rd),
    .xfer_strobe(xfer_strobe), .tc_flag(tc_flag),
    .status_byte(status_byte), .cur_count(cur_count)
  );

  int checks = 0, errs = 0, collisions = 0;
  bit done = 0;

  // behavioural model state
  int m_mode, m_cnt;
  bit m_dis, m_mask, m_tc, m_req, m_sw, m_stat;

  function automatic bit m_can();
    return !m_mask && !m_tc && !m_dis && m_mode != 3;
  endfunction
  function automatic bit m_x();
    return (m_req || m_sw) && m_can();
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit x, hit, can, nreq;
    if (rst) begin
      m_mode = 0; m_dis = 0; m_mask = 1; m_cnt = 0;
      m_tc = 0; m_req = 0; m_sw = 0; m_stat = 0;
      return;
    end
    can = m_can();
    x   = m_x();
    hit = x && m_cnt == 0;
    if (m_mode == 1)      nreq = x ? 1'b0 : (m_req | drq);
    else if (m_mode == 2) nreq = x ? (hit ? drq : m_req) : (m_tc ? drq : (m_req | drq));
    else                  nreq = drq;
    m_req = nreq;
    m_sw  = sw_req || (m_sw && can);
    if (hit)            m_stat = 1;
    else if (status_rd) m_stat = 0;
    if (count_wr) begin m_cnt = count_din; m_tc = 0; end
    else if (x) begin m_cnt = (m_cnt + 65535) % 65536; if (hit) m_tc = 1; end
    if (mode_wr) m_mode = mode_din[5:4];
    if (cmd_wr)  m_dis  = cmd_din[2];
    if (mask_wr) m_mask = mask_din;
  endtask

  task automatic compare();
    int exp_st;
    string rtag;
    exp_st = (int'(m_stat) << CH) | (int'(m_req) << (CH + 4));
    case (m_mode)
      0: rtag = "R1,R3";
      1: rtag = "R1,R4";
      2: rtag = "R1,R5";
      default: rtag = "R1,R6";
    endcase
    chk(xfer_strobe == m_x(), "R2 xfer", xfer_strobe, m_x());
    chk(cur_count == m_cnt, "R7 count", cur_count, m_cnt);
    chk(tc_flag == m_tc, "R8 tc_flag", tc_flag, m_tc);
    chk(status_byte == exp_st, "R9 status", status_byte, exp_st);
    chk(status_byte[CH+4] == m_req, rtag, status_byte[CH+4], m_req);
  endtask

  // one clock: inputs are already set; clear strobes afterwards
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    mode_wr = 0; cmd_wr = 0; mask_wr = 0; count_wr = 0; sw_req = 0; status_rd = 0;
  endtask

  task automatic setup(input int mode, input int cnt);
    mode_wr = 1; mode_din = 8'(mode << 4);
    count_wr = 1; count_din = 16'(cnt);
    mask_wr = 1; mask_din = 0;
    cmd_wr = 1; cmd_din = 0;
    tick();
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog expired");
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
    end
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    rst = 0;
    @(negedge clk);
    chk(status_byte == 0 && cur_count == 0 && !xfer_strobe && !tc_flag, "R11 reset",
        {status_byte, cur_count}, 0);
    // masked after reset: requests must not transfer
    drq = 1; sw_req = 1; tick();
    chk(!xfer_strobe, "R11 masked", xfer_strobe, 0);
    drq = 0; tick(); tick();

    // demand, drop drq mid-run
    setup(0, 5);
    drq = 1; repeat (3) tick();
    drq = 0; repeat (3) tick();
    drq = 1; repeat (8) tick();
    drq = 0; tick();

    // single with steady drq: alternating transfers
    setup(1, 3);
    drq = 1; repeat (10) tick();
    drq = 0; tick();

    // block, one-cycle drq, runs to TC; drq dropped mid-block
    setup(2, 6);
    drq = 1; tick(); drq = 0; repeat (10) tick();
    status_rd = 1; tick();
    // block with mask set mid-transfer
    setup(2, 8);
    drq = 1; tick(); drq = 0; repeat (2) tick();
    mask_wr = 1; mask_din = 1; tick(); repeat (3) tick();
    mask_wr = 1; mask_din = 0; tick(); repeat (10) tick();

    // disable bit while active
    setup(0, 20);
    drq = 1; repeat (3) tick();
    cmd_wr = 1; cmd_din = 8'h04; tick(); repeat (3) tick();
    cmd_wr = 1; cmd_din = 8'h00; tick(); repeat (3) tick();
    drq = 0; tick();

    // cascade: follows drq, never transfers
    setup(3, 4);
    drq = 1; repeat (3) tick(); drq = 0; repeat (2) tick();

    // software request in demand mode with drq low
    setup(0, 2);
    sw_req = 1; tick();
    chk(xfer_strobe == 1, "R10 sw start", xfer_strobe, 1);
    repeat (5) tick();
    chk(!xfer_strobe && tc_flag, "R10 sw stop", {xfer_strobe, tc_flag}, 1);

    // read colliding with TC event, and load colliding with transfer
    setup(2, 1);
    drq = 1; tick(); drq = 0;
    for (int i = 0; i < 6; i++) begin
      if (m_x() && m_cnt == 0) begin status_rd = 1; collisions++; end
      tick();
    end
    setup(0, 3);
    drq = 1; tick(); count_wr = 1; count_din = 16'h0010; tick(); drq = 0; tick();

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      drq = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 9) == 0) status_rd = 1;
      if (m_x() && m_cnt == 0 && $urandom_range(0, 1) == 1) begin status_rd = 1; collisions++; end
      if ($urandom_range(0, 40) == 0) sw_req = 1;
      if ($urandom_range(0, 60) == 0) begin mask_wr = 1; mask_din = 1'($urandom_range(0, 3) == 0); end
      if ($urandom_range(0, 50) == 0) begin count_wr = 1; count_din = 16'($urandom_range(0, 12)); end
      if ($urandom_range(0, 80) == 0) begin mode_wr = 1; mode_din = 8'($urandom_range(0, 255)); end
      if ($urandom_range(0, 90) == 0) begin cmd_wr = 1; cmd_din = 8'($urandom_range(0, 255)); end
      tick();
    end
    chk(collisions > 0, "R9 collision seen", collisions, 1);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
    end
    $finish;
  end

endmodule